// File: doc/BRIEF.md
# Alternate-Line Inversion Link Encoder and Decoder

This block cuts the coupling activity between neighbouring wires of a narrow on-chip link. The sender widens each payload word by one line, which carries an inversion flag. On every accepted word it compares the new payload with the payload currently held on the link. For each pair of neighbouring payload lines it asks one question: would the pair see a transition in which exactly one of the two wires toggles? A majority vote over all pairs then decides between two choices. The encoder sends the payload as it is, or it complements every odd-indexed payload line and raises the flag, whichever gives fewer such transitions.

The encoded word is registered, so it reaches the link one clock after the input is accepted, and it stays there until the next accepted word. The receive side is a combinational decoder. When the flag is set it complements the odd-indexed payload lines again, and otherwise it passes the payload through. In a system the link output of one instance drives the link input of the peer. Both ends start from an all-zero link after reset.

Top module: `odd_inv_link`

## Requirements
- R1: While reset is active and after its release, before any word is accepted, the link word is all zeros and the link-valid output is low.
- R2: A payload presented with the input-valid strobe high appears encoded on the link one clock later, and link-valid is high in exactly the cycle after an input-valid cycle.
- R3: In a cycle where input-valid is low, the link word does not change.
- R4: The flag is the top link line (index LINK_W-1). When it is 0 the payload lines equal the input payload. When it is 1, payload lines at indices 1, 3, 5, … are the complement of the input and lines at indices 0, 2, 4, … equal the input.
- R5: A pair (i, i+1) of payload lines counts as single-toggle when exactly one of the two lines differs between the held link payload and the new input payload. The flag is set when the single-toggle pairs outnumber the other pairs.
- R6: When single-toggle and other pairs are equal in number, the word is sent with the flag at 0.
- R7: The decoder output equals the link-input payload with its odd-indexed lines complemented when the link-input flag is 1, and unchanged when it is 0.
- R8: With the link output fed back into the link input, the decoder output in every link-valid cycle equals the payload accepted in the previous cycle.
- R9: The number of single-toggle pairs between two successive link words never exceeds the number that sending the new payload unencoded would cause, and never exceeds floor((LINK_W-2)/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Payload accept strobe |
| inData | input | LINK_W-1 | Payload to send |
| linkOut | output | LINK_W | Registered encoded link word, flag on top |
| linkValid | output | 1 | Link word was updated on the last edge |
| linkIn | input | LINK_W | Received encoded link word |
| decData | output | LINK_W-1 | Decoded payload |

## Verification
The checks that run on every cycle cover the link hold on idle cycles, link-valid following input-valid by one clock, an unflagged word carrying the payload as it is, the loop-back round trip, and the bound of floor((LINK_W-2)/2) single-toggle pairs between successive link words. Only the bench's scenarios show the exact vote. This covers the tie that must stay uninverted, the all-pairs case that must invert, and the comparison against the unencoded transition count over a random stream. The scenarios also cover the decoder on link words that the encoder never produced, and the reset state.

// File: rtl/odd_inv_pkg.sv
package odd_inv_pkg;
  // Strobes from the vote logic to the datapath
  typedef struct packed {
    logic load;    // capture a new link word
    logic invOdd;  // complement odd payload lines and raise the flag
  } encStrobe_t;
endpackage

// File: rtl/odd_inv_datapath.sv
module odd_inv_datapath #(
  parameter int LINK_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [LINK_W-2:0]          inData,
  input  odd_inv_pkg::encStrobe_t    strobe,
  output logic [LINK_W-3:0]          typeIVec,
  output logic [LINK_W-1:0]          linkOut
);
  localparam int PAY_W = LINK_W - 1;
  localparam int NPAIR = PAY_W - 1;
  localparam int CNT_W = $clog2(NPAIR + 1) + 1;

  logic [LINK_W-1:0] linkReg;
  logic [PAY_W-1:0]  prevPay;
  logic [PAY_W-1:0]  toggles;
  logic [PAY_W-1:0]  oddMask;
  logic [PAY_W-1:0]  sendPay;

  assign prevPay = linkReg[PAY_W-1:0];
  assign toggles = prevPay ^ inData;

  // One single-toggle detector per neighbouring payload pair
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    assign typeIVec[g] = toggles[g] ^ toggles[g+1];
  end

  for (genvar g = 0; g < PAY_W; g++) begin : g_mask
    assign oddMask[g] = 1'(g % 2);
  end

  assign sendPay = strobe.invOdd ? (inData ^ oddMask) : inData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      linkReg <= '0;
    else if (strobe.load)
      linkReg <= {strobe.invOdd, sendPay};
  end

  assign linkOut = linkReg;

  function automatic logic [CNT_W-1:0] pairCount(input logic [LINK_W-1:0] a,
                                                 input logic [LINK_W-1:0] b);
    logic [PAY_W-1:0] t;
    logic [CNT_W-1:0] c;
    t = a[PAY_W-1:0] ^ b[PAY_W-1:0];
    c = '0;
    for (int i = 0; i < NPAIR; i++) c = c + CNT_W'(t[i] ^ t[i+1]);
    return c;
  endfunction

  // R3: idle cycles leave the link untouched
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(linkReg));

  // R4: an unflagged word carries the payload verbatim
  p_plain_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.invOdd) |=>
      (!linkReg[LINK_W-1] && linkReg[PAY_W-1:0] == $past(inData)));

  // R9: successive link words never exceed half the pairs in single toggles
  p_pair_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (pairCount($past(linkReg), linkReg) <= CNT_W'(NPAIR / 2)));
endmodule

// File: rtl/odd_inv_control.sv
module odd_inv_control #(
  parameter int LINK_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic [LINK_W-3:0]          typeIVec,
  output odd_inv_pkg::encStrobe_t    strobe,
  output logic                       linkValid
);
  localparam int NPAIR = LINK_W - 2;
  localparam int CNT_W = $clog2(NPAIR + 1) + 2;

  logic [CNT_W-1:0] voteCnt;
  logic             majority;
  logic             validQ;

  always_comb begin
    voteCnt = '0;
    for (int i = 0; i < NPAIR; i++) voteCnt = voteCnt + CNT_W'(typeIVec[i]);
  end

  // Strict majority; a tie keeps the word uninverted
  assign majority = (voteCnt << 1) > CNT_W'(NPAIR);

  always_comb begin
    strobe.load   = inValid;
    strobe.invOdd = inValid & majority;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  assign linkValid = validQ;

  // R2: link-valid tracks input-valid by one clock
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> linkValid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !linkValid);
endmodule

// File: rtl/odd_inv_decoder.sv
module odd_inv_decoder #(
  parameter int LINK_W = 8
) (
  input  logic [LINK_W-1:0] linkIn,
  output logic [LINK_W-2:0] decData
);
  localparam int PAY_W = LINK_W - 1;

  logic [PAY_W-1:0] flipMask;

  for (genvar g = 0; g < PAY_W; g++) begin : g_flip
    assign flipMask[g] = linkIn[LINK_W-1] & 1'(g % 2);
  end

  assign decData = linkIn[PAY_W-1:0] ^ flipMask;
endmodule

// File: rtl/odd_inv_link.sv
module odd_inv_link #(
  parameter int LINK_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [LINK_W-2:0] inData,
  output logic [LINK_W-1:0] linkOut,
  output logic              linkValid,
  input  logic [LINK_W-1:0] linkIn,
  output logic [LINK_W-2:0] decData
);
  odd_inv_pkg::encStrobe_t strobe;
  logic [LINK_W-3:0]       typeIVec;

  odd_inv_control #(.LINK_W(LINK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .typeIVec(typeIVec),
    .strobe(strobe), .linkValid(linkValid));

  odd_inv_datapath #(.LINK_W(LINK_W)) u_dp (
    .clk(clk), .rstN(rstN), .inData(inData), .strobe(strobe),
    .typeIVec(typeIVec), .linkOut(linkOut));

  odd_inv_decoder #(.LINK_W(LINK_W)) u_dec (
    .linkIn(linkIn), .decData(decData));

  // R8: looped-back link recovers the accepted payload
  p_round_trip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (linkValid && linkIn == linkOut) |-> (decData == $past(inData)));
endmodule

// File: tb/odd_inv_link_tb.sv
module odd_inv_link_tb;
  localparam int LW = 8;
  localparam int PW = LW - 1;
  localparam int NP = PW - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [PW-1:0] inData = '0;
  logic [LW-1:0] linkOut;
  logic          linkValid;
  logic [LW-1:0] linkIn;
  logic [PW-1:0] decData;
  logic          useLoop = 1'b1;
  logic [LW-1:0] forcedLink = '0;

  int checks = 0;
  int failures = 0;
  logic [LW-1:0] modelLink = '0;
  logic [15:0]   lfsr = 16'hACE1;

  always #4 clk = ~clk;

  always_comb linkIn = useLoop ? linkOut : forcedLink;

  odd_inv_link #(.LINK_W(LW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .linkOut(linkOut), .linkValid(linkValid), .linkIn(linkIn), .decData(decData));

  // Stimulus table: {valid, payload}
  localparam logic [LW-1:0] VEC [16] = '{
    8'h80, 8'hFF, 8'h80, 8'h7F, 8'h2A, 8'h00, 8'hD5, 8'hAA,
    8'h81, 8'h01, 8'hC3, 8'h9C, 8'h00, 8'hE0, 8'h8F, 8'hB6};

  function automatic logic [PW-1:0] oddMask();
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i % 2 == 1);
    return m;
  endfunction

  function automatic int singles(input logic [PW-1:0] a, input logic [PW-1:0] b);
    int c = 0;
    logic [PW-1:0] t = a ^ b;
    for (int i = 0; i < NP; i++) if (t[i] != t[i+1]) c++;
    return c;
  endfunction

  function automatic logic [LW-1:0] expectLink(input logic [LW-1:0] prev,
                                               input logic [PW-1:0] d);
    int c = singles(prev[PW-1:0], d);
    if (2 * c > NP) return {1'b1, d ^ oddMask()};
    return {1'b0, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; drives, waits one clock, checks at the next negedge
  task automatic step(input logic v, input logic [PW-1:0] d);
    logic [LW-1:0] prev = modelLink;
    logic [LW-1:0] exp = v ? expectLink(prev, d) : prev;
    inValid = v;
    inData  = d;
    @(negedge clk);
    check(linkValid == v, "R2 link-valid", {7'd0, linkValid}, {7'd0, v});
    check(linkOut == exp, v ? "R5 encoded word" : "R3 idle hold", linkOut, exp);
    if (v) begin
      check(decData == d, "R8 round trip", {1'b0, decData}, {1'b0, d});
      check(singles(prev[PW-1:0], linkOut[PW-1:0]) <= singles(prev[PW-1:0], d),
            "R9 single-toggle bound", LW'(singles(prev[PW-1:0], linkOut[PW-1:0])),
            LW'(singles(prev[PW-1:0], d)));
    end
    modelLink = exp;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check(linkOut == '0 && !linkValid, "R1 reset state", linkOut, '0);
    rstN = 1'b1;
    modelLink = '0;
    @(negedge clk);
    check(linkOut == '0 && !linkValid, "R1 after release", linkOut, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();

    // Table walk
    for (int i = 0; i < 16; i++) step(VEC[i][LW-1], VEC[i][PW-1:0]);

    // R6: tie, three single-toggle pairs out of six, from zero
    doReset();
    step(1'b1, 7'h05);
    check(linkOut == 8'h05, "R6 tie stays plain", linkOut, 8'h05);

    // R4: every pair single-toggle from zero -> flagged, all ones
    doReset();
    step(1'b1, 7'h55);
    check(linkOut == 8'hFF, "R4 odd inversion and flag", linkOut, 8'hFF);
    step(1'b0, 7'h12);
    check(linkOut == 8'hFF, "R3 hold after idle", linkOut, 8'hFF);

    // R7: decoder on words driven directly
    useLoop = 1'b0;
    forcedLink = 8'h80; #1;
    check(decData == 7'h2A, "R7 flag only", {1'b0, decData}, 8'h2A);
    forcedLink = 8'hD5; #1;
    check(decData == 7'h7F, "R7 flagged word", {1'b0, decData}, 8'h7F);
    forcedLink = 8'h55; #1;
    check(decData == 7'h55, "R7 unflagged word", {1'b0, decData}, 8'h55);
    useLoop = 1'b1;
    @(negedge clk);

    // Random stream with occasional idle cycles
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[9:7] != 3'b000, lfsr[6:0]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule